// File: doc/BRIEF.md
# Full-Circle CORDIC Twiddle Table Builder

This block fills a table of cosine and sine pairs for a transform engine. Angle words are first loaded into an internal angle store. A single start pulse then sweeps every address of that store in ascending order, one angle per clock, through an unrolled chain of shift-and-add micro-rotation stages in rotation mode. Each finished pair lands in a twiddle result store at the same address as its angle. The transform engine reads the result store through its own read port, which works at any time.

Angles use a binary-turn encoding: the full 16-bit word range is one revolution, so 0x4000 is a quarter turn. The micro-rotation chain only converges within about a quarter turn either side of zero. A front stage therefore folds the two left-hand quadrants onto the right-hand half by a half-turn shift, and the final stage negates both outputs. The starting x value is the inverse of the cumulative rotation gain, so no multiplier is needed. The sweep runs without stalls and the block applies no back-pressure. A busy flag covers the sweep, and a done flag marks that the last result has been written.

Top module: `cordic_twiddle_gen`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: A `start` pulse while `busy` is low sets `busy` and clears `done` at the next clock edge.
- R3: For an angle word a in the angle store, with θ = 2π·a/65536, the result at the same address is cos θ and sin θ scaled so that 1.0 = 2^(OUT_W−2) (16384 at the defaults). Each value is within 8 LSB of round(16384·cos θ) and round(16384·sin θ), in all four quadrants. The quadrant is given by the top two angle bits.
- R4: Angles on or next to the quadrant edges give results within the same 8 LSB. These are 0x3FFF/0x4000/0x4001, 0x7FFF/0x8000, 0xBFFF/0xC000 and 0xFFFF.
- R5: Results are written one per clock in ascending address order. The pair computed from angle address k is stored at result address k.
- R6: `done` rises, and `busy` falls, at clock edge number 2^ADDR_W + ITER + 3 after the edge that sampled `start` (83 at the defaults). Before that edge `done` stays low.
- R7: A `start` pulse while `busy` is high is ignored. The sweep and its `done` timing are unchanged.
- R8: Writes to the angle store while `busy` is high are ignored. The stored angle keeps its old value.
- R9: The result read port is registered. `tw_cos`/`tw_sin` show the pair at `tw_raddr` after the next clock edge.
- R10: `done` stays high until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a sweep of all angle addresses |
| ang_we | input | 1 | Angle store write enable (ignored while busy) |
| ang_waddr | input | ADDR_W | Angle store write address |
| ang_wdata | input | 16 | Angle word, binary-turn encoding |
| tw_raddr | input | ADDR_W | Result store read address |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Last result written; held until the next start |
| tw_cos | output | OUT_W | Cosine at tw_raddr, registered |
| tw_sin | output | OUT_W | Sine at tw_raddr, registered |

## Verification
The result for angle address k is written ITER + 4 + k edges after the start edge. This covers the store read, the fold, ITER rotation stages, the rounding register and the store write. `done` therefore rises on edge 2^ADDR_W + ITER + 3. The bench counts exactly that many edges from the start pulse. It samples `done` low one edge earlier and high on that edge, with or without a mid-sweep start or angle write. Stored pairs are read back with one edge between setting `tw_raddr` and sampling. Each pair is compared against arithmetically computed cosine and sine, for a regular grid of angles, for quadrant edges and for pseudo-random angles.

// File: rtl/cordic_tw_pkg.sv
`timescale 1ns/1ps
package cordic_tw_pkg;
  // Angles are binary turns: full word range = one revolution.
  localparam int ANG_W    = 16;
  localparam int MAX_ITER = 16;
  // Inverse CORDIC gain (product of cos(atan(2^-i))) in Q1.31
  localparam longint GAIN_INV_Q31 = 64'd1304065748;

  // atan(2^-i) expressed in binary-turn units of a 16-bit angle
  function automatic logic signed [ANG_W-1:0] atan_turn(input int i);
    case (i)
      0:  return 16'sd8192;
      1:  return 16'sd4836;
      2:  return 16'sd2555;
      3:  return 16'sd1297;
      4:  return 16'sd651;
      5:  return 16'sd326;
      6:  return 16'sd163;
      7:  return 16'sd81;
      8:  return 16'sd41;
      9:  return 16'sd20;
      10: return 16'sd10;
      11: return 16'sd5;
      12: return 16'sd3;
      13: return 16'sd1;
      14: return 16'sd1;
      default: return 16'sd0;
    endcase
  endfunction
endpackage

// File: rtl/tw_ram.sv
`timescale 1ns/1ps
module tw_ram #(
  parameter int DW     = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cordic_sweep_ctrl.sv
`timescale 1ns/1ps
module cordic_sweep_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              last_wr,
  output logic              busy,
  output logic              done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam logic [ADDR_W-1:0] LAST = '1;
  logic issuing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      issuing <= 1'b0;
      rd_addr <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      issuing <= 1'b1;
      rd_addr <= '0;
    end else begin
      if (issuing) begin
        rd_addr <= rd_addr + ADDR_W'(1);
        if (rd_addr == LAST) issuing <= 1'b0;
      end
      if (last_wr) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign rd_en = issuing;

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));
endmodule

// File: rtl/cordic_fold.sv
`timescale 1ns/1ps
module cordic_fold
  import cordic_tw_pkg::*;
#(
  parameter int IW     = 18,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vld_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [ANG_W-1:0]        ang_i,
  output logic                    vld_o,
  output logic                    neg_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic signed [IW-1:0]    x_o,
  output logic signed [IW-1:0]    y_o,
  output logic signed [ANG_W-1:0] z_o
);
  localparam int     AMP_B  = IW - 2;
  localparam longint XI     = ((GAIN_INV_Q31 >>> (31 - AMP_B - 1)) + 64'sd1) >>> 1;
  localparam logic signed [IW-1:0]    X_INIT = IW'(XI);
  localparam logic signed [ANG_W-1:0] QTR    = ANG_W'(1) << (ANG_W - 2);

  // Second and third quadrants are moved by half a turn.
  logic half_turn;
  assign half_turn = ang_i[ANG_W-1] ^ ang_i[ANG_W-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else        vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    neg_o  <= half_turn;
    addr_o <= addr_i;
    x_o    <= X_INIT;
    y_o    <= '0;
    z_o    <= half_turn ? {~ang_i[ANG_W-1], ang_i[ANG_W-2:0]} : ang_i;
  end

  // R3
  fold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (z_o >= -QTR && z_o <= QTR));
endmodule

// File: rtl/cordic_stage.sv
`timescale 1ns/1ps
module cordic_stage
  import cordic_tw_pkg::*;
#(
  parameter int IW     = 18,
  parameter int ADDR_W = 6,
  parameter int SHIFT  = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vld_i,
  input  logic                    neg_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic signed [IW-1:0]    x_i,
  input  logic signed [IW-1:0]    y_i,
  input  logic signed [ANG_W-1:0] z_i,
  output logic                    vld_o,
  output logic                    neg_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic signed [IW-1:0]    x_o,
  output logic signed [IW-1:0]    y_o,
  output logic signed [ANG_W-1:0] z_o
);
  localparam logic signed [ANG_W-1:0] STEP = atan_turn(SHIFT);

  logic signed [IW-1:0] x_sh, y_sh;
  assign x_sh = x_i >>> SHIFT;
  assign y_sh = y_i >>> SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else        vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    neg_o  <= neg_i;
    addr_o <= addr_i;
    if (!z_i[ANG_W-1]) begin
      x_o <= x_i - y_sh;
      y_o <= y_i + x_sh;
      z_o <= z_i - STEP;
    end else begin
      x_o <= x_i + y_sh;
      y_o <= y_i - x_sh;
      z_o <= z_i + STEP;
    end
  end
endmodule

// File: rtl/cordic_twiddle_gen.sv
`timescale 1ns/1ps
module cordic_twiddle_gen
  import cordic_tw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int ITER   = 16,
  parameter int OUT_W  = 16,
  parameter int GUARD  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     ang_we,
  input  logic [ADDR_W-1:0]        ang_waddr,
  input  logic [ANG_W-1:0]         ang_wdata,
  input  logic [ADDR_W-1:0]        tw_raddr,
  output logic                     busy,
  output logic                     done,
  output logic signed [OUT_W-1:0]  tw_cos,
  output logic signed [OUT_W-1:0]  tw_sin
);
  localparam int IW = OUT_W + GUARD;
  localparam logic [ADDR_W-1:0]       LAST  = '1;
  localparam logic signed [IW-1:0]    RND   = IW'(1) << (GUARD - 1);
  localparam logic signed [ANG_W-1:0] Z_TOL = 16'sd16;

  // sequencer
  logic              rd_en, last_wr;
  logic [ADDR_W-1:0] rd_addr;

  cordic_sweep_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .last_wr(last_wr),
    .busy(busy), .done(done), .rd_en(rd_en), .rd_addr(rd_addr)
  );

  // angle store
  logic [ANG_W-1:0] ang_q;
  tw_ram #(.DW(ANG_W), .ADDR_W(ADDR_W)) u_ang_ram (
    .clk(clk), .we(ang_we && !busy), .waddr(ang_waddr), .wdata(ang_wdata),
    .raddr(rd_addr), .rdata(ang_q)
  );

  logic              rd_vld;
  logic [ADDR_W-1:0] rd_tag;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld <= 1'b0;
    else        rd_vld <= rd_en;
  end
  always_ff @(posedge clk) rd_tag <= rd_addr;

  // rotation pipeline
  logic                    vs [0:ITER];
  logic                    ns [0:ITER];
  logic [ADDR_W-1:0]       as [0:ITER];
  logic signed [IW-1:0]    xs [0:ITER];
  logic signed [IW-1:0]    ys [0:ITER];
  logic signed [ANG_W-1:0] zs [0:ITER];

  cordic_fold #(.IW(IW), .ADDR_W(ADDR_W)) u_fold (
    .clk(clk), .rst_n(rst_n), .vld_i(rd_vld), .addr_i(rd_tag), .ang_i(ang_q),
    .vld_o(vs[0]), .neg_o(ns[0]), .addr_o(as[0]),
    .x_o(xs[0]), .y_o(ys[0]), .z_o(zs[0])
  );

  for (genvar g = 0; g < ITER; g++) begin : g_stage
    cordic_stage #(.IW(IW), .ADDR_W(ADDR_W), .SHIFT(g)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .vld_i(vs[g]), .neg_i(ns[g]), .addr_i(as[g]),
      .x_i(xs[g]), .y_i(ys[g]), .z_i(zs[g]),
      .vld_o(vs[g+1]), .neg_o(ns[g+1]), .addr_o(as[g+1]),
      .x_o(xs[g+1]), .y_o(ys[g+1]), .z_o(zs[g+1])
    );
  end

  // rounding and quadrant sign correction
  function automatic logic signed [OUT_W-1:0] round_out(input logic signed [IW-1:0] v);
    logic signed [IW-1:0] s;
    s = v + RND;
    return s[IW-1:GUARD];
  endfunction

  logic signed [OUT_W-1:0] cos_r, sin_r;
  assign cos_r = round_out(xs[ITER]);
  assign sin_r = round_out(ys[ITER]);

  logic                    wr_vld;
  logic [ADDR_W-1:0]       wr_addr;
  logic signed [OUT_W-1:0] wr_cos, wr_sin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_vld <= 1'b0;
    else        wr_vld <= vs[ITER];
  end
  always_ff @(posedge clk) begin
    wr_addr <= as[ITER];
    wr_cos  <= ns[ITER] ? -cos_r : cos_r;
    wr_sin  <= ns[ITER] ? -sin_r : sin_r;
  end

  assign last_wr = wr_vld && (wr_addr == LAST);

  // result store
  logic [2*OUT_W-1:0] tw_q;
  tw_ram #(.DW(2*OUT_W), .ADDR_W(ADDR_W)) u_tw_ram (
    .clk(clk), .we(wr_vld), .waddr(wr_addr), .wdata({wr_cos, wr_sin}),
    .raddr(tw_raddr), .rdata(tw_q)
  );
  assign tw_cos = tw_q[2*OUT_W-1:OUT_W];
  assign tw_sin = tw_q[OUT_W-1:0];

  // R3
  residual_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs[ITER] |-> (zs[ITER] >= -Z_TOL && zs[ITER] <= Z_TOL));

  // R5
  wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && $past(wr_vld)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(last_wr));

  // R6
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
endmodule

// File: tb/cordic_twiddle_gen_bench.sv
`timescale 1ns/1ps
module cordic_twiddle_gen_bench;
  localparam int ADDR_W = 6;
  localparam int ITER   = 16;
  localparam int OUT_W  = 16;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DONE_EDGE = DEPTH + ITER + 3;
  localparam int TOL    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ang_we = 1'b0;
  logic [ADDR_W-1:0] ang_waddr = '0;
  logic [15:0] ang_wdata = '0;
  logic [ADDR_W-1:0] tw_raddr = '0;
  logic busy, done;
  logic signed [OUT_W-1:0] tw_cos, tw_sin;

  int checks = 0;
  int errors = 0;
  logic [15:0] ang_ref [0:DEPTH-1];

  always #10 clk = ~clk;

  cordic_twiddle_gen #(.ADDR_W(ADDR_W), .ITER(ITER), .OUT_W(OUT_W), .GUARD(2)) u_cordic_twiddle_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .ang_we(ang_we),
    .ang_waddr(ang_waddr), .ang_wdata(ang_wdata), .tw_raddr(tw_raddr),
    .busy(busy), .done(done), .tw_cos(tw_cos), .tw_sin(tw_sin)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ideal(input logic [15:0] a, input bit want_sin);
    real th;
    th = 2.0 * 3.14159265358979 * real'(a) / 65536.0;
    if (want_sin) return $rtoi($floor(16384.0 * $sin(th) + 0.5));
    return $rtoi($floor(16384.0 * $cos(th) + 0.5));
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic load_all();
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      ang_we = 1'b1; ang_waddr = ADDR_W'(k); ang_wdata = ang_ref[k];
    end
    @(negedge clk);
    ang_we = 1'b0;
  endtask

  // Sweep with exact done timing; optional mid-sweep start and angle write.
  task automatic run_sweep(input bit probe);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    chk(done == 1'b0, "R2 done cleared", int'(done), 0);
    for (int i = 1; i < DONE_EDGE; i++) begin
      @(negedge clk);
      start  = (probe && i == 10);
      ang_we = (probe && i == 20);
      ang_waddr = '0;
      ang_wdata = 16'h1234;
    end
    start = 1'b0; ang_we = 1'b0;
    chk(done == 1'b0, probe ? "R7 done not early" : "R6 done not early", int'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, probe ? "R7 done on time" : "R6 done on time", int'(done), 1);
    chk(busy == 1'b0, "R6 busy falls", int'(busy), 0);
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < DEPTH; k++) begin
      int ec, es;
      @(negedge clk);
      tw_raddr = ADDR_W'(k);
      @(negedge clk);
      ec = ideal(ang_ref[k], 1'b0);
      es = ideal(ang_ref[k], 1'b1);
      chk(iabs(int'(tw_cos) - ec) <= TOL, {req, " cos (R9 read)"}, int'(tw_cos), ec);
      chk(iabs(int'(tw_sin) - es) <= TOL, {req, " sin (R9 read)"}, int'(tw_sin), es);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done reset", int'(done), 0);

    // Sweep 1: regular grid over the full turn (R3, R5)
    for (int k = 0; k < DEPTH; k++) ang_ref[k] = 16'(k * 1024);
    load_all();
    run_sweep(1'b0);
    check_all("R3 R5 grid");
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R10 done held", int'(done), 1);

    // Sweep 2: quadrant edges then pseudo-random angles (R4, R3)
    ang_ref[0] = 16'h3FFF; ang_ref[1] = 16'h4000; ang_ref[2] = 16'h4001;
    ang_ref[3] = 16'h7FFF; ang_ref[4] = 16'h8000; ang_ref[5] = 16'hBFFF;
    ang_ref[6] = 16'hC000; ang_ref[7] = 16'hFFFF; ang_ref[8] = 16'h0000;
    ang_ref[9] = 16'h0001; ang_ref[10] = 16'h8001; ang_ref[11] = 16'hC001;
    seed = 32'h1ACE;
    for (int k = 12; k < DEPTH; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      ang_ref[k] = seed[30:15];
    end
    load_all();
    run_sweep(1'b1);
    check_all("R4 R3 edges/random");

    // Sweep 3: no reload; angle write during sweep 2 must not have landed (R8)
    run_sweep(1'b0);
    @(negedge clk);
    tw_raddr = '0;
    @(negedge clk);
    chk(iabs(int'(tw_cos) - ideal(ang_ref[0], 1'b0)) <= TOL, "R8 angle kept cos",
        int'(tw_cos), ideal(ang_ref[0], 1'b0));
    chk(iabs(int'(tw_sin) - ideal(ang_ref[0], 1'b1)) <= TOL, "R8 angle kept sin",
        int'(tw_sin), ideal(ang_ref[0], 1'b1));
    check_all("R5 rerun");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule